// File: doc/BRIEF.md
# Tile Temperature Emulator

This block stands in for an analogue temperature sensor that covers a whole tile of processor cores, using only digital logic. Each core has its own power monitor. At the end of every monitoring period the power monitors present one power value per core together with a strobe. The block reduces each power value to a small level and marks a core with zero power as inactive. For every core it builds a table index from that core's level and the levels of its two neighbours in the row. A pre-characterised table of steady-state temperatures is read at each index. Each table entry already includes the core's own heating, the pattern of active cores and the heat coupled in from its neighbours.

The block reports one temperature for the tile. This value is the highest steady-state temperature found over all cores in the period, and it comes with a one-cycle valid pulse. The table is filled through a simple write port before use. Computing the thermal model that produces the table contents is left to whoever fills the table.

A three-state machine controls the lookup. IDLE waits for a power strobe. The transition *accept* moves it from IDLE to SCAN; it captures all the levels and clears the running maximum. SCAN reads one core per cycle through a single table read port. The transition *next core* keeps it in SCAN while cores remain to be read. The transition *last core* moves it to DONE after core NCORES-1. DONE publishes the maximum and pulses valid. The transition *publish* then returns it to IDLE. A strobe that arrives while the machine is outside IDLE is dropped and sets a sticky overrun flag.

Top module: `tile_temp_emu`

## Requirements
- R1: Each core's power (PWR_W bits) becomes a level of LVL_W bits. Zero power gives level 0 (inactive). A non-zero power gives its top LVL_W bits, but never less than 1. With the defaults, power 0 gives 0, powers 1..127 give 1, 128..191 give 2 and 192..255 give 3.
- R2: The table index of core i is {level(i), level(i-1), level(i+1)}, with the own level in the most significant field. A neighbour that lies outside the row (i-1 for core 0, i+1 for the last core) contributes level 0.
- R3: The reported tile temperature equals the largest table entry read over all cores for the strobed powers.
- R4: temp_valid is a one-cycle pulse. It first appears NCORES+1 clock edges after the edge that accepts the power strobe.
- R5: After reset, tile_temp is 0 and temp_valid and overrun are low. tile_temp holds its value between valid pulses.
- R6: A power strobe seen while a period is still being processed is ignored; the result in progress uses the earlier powers. Such a strobe sets overrun, which stays high until reset.
- R7: A table write (tbl_wr with tbl_addr and tbl_data) changes the entry seen by every lookup from the following period on.
- R8: The running maximum is cleared at the start of each period, so a cooler period reports a lower temperature than a hotter one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_valid | input | 1 | End-of-period strobe for the power values |
| pwr_in | input | NCORES*PWR_W | Per-core power, core i in bits [i*PWR_W +: PWR_W] |
| tbl_wr | input | 1 | Table write enable |
| tbl_addr | input | 3*LVL_W | Table write index |
| tbl_data | input | TEMP_W | Table write temperature |
| tile_temp | output | TEMP_W | Maximum steady-state temperature of the tile |
| temp_valid | output | 1 | One-cycle pulse when tile_temp is updated |
| overrun | output | 1 | Sticky flag: a strobe arrived during a scan |

## Verification
The assertions check on every cycle the timing side of the block. They cover the exact latency from an accepted strobe to the valid pulse and the one-cycle width of that pulse. They also check that tile_temp holds between pulses and that a strobe arriving while busy raises overrun, which then never falls. The values cannot be checked that way. The quantisation boundaries, the neighbour ordering of the index, the zero level at the row ends, the maximum over cores, the effect of a table rewrite and the clearing of the maximum between periods only show up in the bench scenarios. There, a random table, random powers and directed boundary powers are compared against a model of the table lookup.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } tpe_state_e;

endpackage

// File: rtl/tpe_quant.sv
// Power-to-level quantiser for one core.
module tpe_quant #(
    parameter int PWR_W = 8,
    parameter int LVL_W = 2
) (
    input  logic [PWR_W-1:0] pwr,
    output logic [LVL_W-1:0] lvl
);

    logic [LVL_W-1:0] top_bits;

    assign top_bits = pwr[PWR_W-1 -: LVL_W];

    always_comb begin
        if (pwr == '0) begin
            lvl = '0;
        end else if (top_bits == '0) begin
            lvl = LVL_W'(1);
        end else begin
            lvl = top_bits;
        end
    end

endmodule

// File: rtl/tpe_table.sv
// Steady-state temperature table: one write port, one combinational read port.
module tpe_table #(
    parameter int IDX_W  = 6,
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [TEMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [TEMP_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [TEMP_W-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            entry_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_addr];

endmodule

// File: rtl/tpe_seq.sv
// Scan sequencer: one lookup per core, running maximum, publish and overrun.
module tpe_seq
    import tpe_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int IDX_W  = 6,
    parameter int TEMP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_req,
    input  logic [NCORES*IDX_W-1:0] idx_all,
    input  logic [TEMP_W-1:0]       rd_data,
    output logic [IDX_W-1:0]        rd_addr,
    output logic                    capture,
    output logic                    busy,
    output logic [TEMP_W-1:0]       temp_q,
    output logic                    valid_q,
    output logic                    overrun_q
);

    localparam int CNT_W = (NCORES > 1) ? $clog2(NCORES) : 1;
    localparam logic [CNT_W-1:0] LAST_CORE = CNT_W'(NCORES - 1);

    tpe_state_e        state_q, state_d;
    logic [CNT_W-1:0]  core_q;
    logic [TEMP_W-1:0] max_q;

    assign busy    = (state_q != ST_IDLE);
    assign capture = start_req && !busy;
    assign rd_addr = idx_all[core_q*IDX_W +: IDX_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, next core, last core, publish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_SCAN;
            ST_SCAN: if (core_q == LAST_CORE) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= '0;
            max_q     <= '0;
            temp_q    <= '0;
            valid_q   <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start_req && busy) begin
                overrun_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        core_q <= '0;
                        max_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (rd_data > max_q) begin
                        max_q <= rd_data;
                    end
                    if (core_q != LAST_CORE) begin
                        core_q <= core_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    temp_q  <= max_q;
                    valid_q <= 1'b1;
                end
                default: begin
                    core_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tile_temp_emu.sv
// Tile temperature emulator: quantise, index by neighbourhood, look up, take maximum.
module tile_temp_emu
    import tpe_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int PWR_W  = 8,
    parameter int LVL_W  = 2,
    parameter int TEMP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_valid,
    input  logic [NCORES*PWR_W-1:0] pwr_in,
    input  logic                    tbl_wr,
    input  logic [3*LVL_W-1:0]      tbl_addr,
    input  logic [TEMP_W-1:0]       tbl_data,
    output logic [TEMP_W-1:0]       tile_temp,
    output logic                    temp_valid,
    output logic                    overrun
);

    localparam int IDX_W = 3 * LVL_W;

    logic [LVL_W-1:0]        lvl_d [NCORES];
    logic [LVL_W-1:0]        lvl_q [NCORES];
    logic [NCORES*IDX_W-1:0] idx_all;
    logic [IDX_W-1:0]        rd_addr;
    logic [TEMP_W-1:0]       rd_data;
    logic                    capture;
    logic                    busy;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [LVL_W-1:0] left_lvl;
        logic [LVL_W-1:0] right_lvl;

        tpe_quant #(
            .PWR_W (PWR_W),
            .LVL_W (LVL_W)
        ) u_quant (
            .pwr (pwr_in[c*PWR_W +: PWR_W]),
            .lvl (lvl_d[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q[c] <= '0;
            end else if (capture) begin
                lvl_q[c] <= lvl_d[c];
            end
        end

        if (c == 0) begin : g_left_edge
            assign left_lvl = '0;
        end else begin : g_left_in
            assign left_lvl = lvl_q[c-1];
        end

        if (c == NCORES - 1) begin : g_right_edge
            assign right_lvl = '0;
        end else begin : g_right_in
            assign right_lvl = lvl_q[c+1];
        end

        assign idx_all[c*IDX_W +: IDX_W] = {lvl_q[c], left_lvl, right_lvl};
    end

    tpe_table #(
        .IDX_W  (IDX_W),
        .TEMP_W (TEMP_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tpe_seq #(
        .NCORES (NCORES),
        .IDX_W  (IDX_W),
        .TEMP_W (TEMP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (pwr_valid),
        .idx_all   (idx_all),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .capture   (capture),
        .busy      (busy),
        .temp_q    (tile_temp),
        .valid_q   (temp_valid),
        .overrun_q (overrun)
    );

endmodule

// File: rtl/tile_temp_emu_chk.sv
module tile_temp_emu_chk #(
    parameter int NCORES = 4,
    parameter int TEMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_valid,
    input logic              busy,
    input logic [TEMP_W-1:0] tile_temp,
    input logic              temp_valid,
    input logic              overrun
);

    localparam int LAT_W = $clog2(NCORES + 4) + 1;

    logic [LAT_W-1:0] since_q;

    // Counts edges since the accepted strobe; cleared by the valid pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (pwr_valid && !busy) begin
            since_q <= LAT_W'(1);
        end else if (temp_valid) begin
            since_q <= '0;
        end else if (since_q != '0) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |=> !temp_valid);

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |-> (since_q == LAT_W'(NCORES + 2)));

    a_r5_temp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |-> $stable(tile_temp));

    a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_valid && busy) |=> overrun);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind tile_temp_emu tile_temp_emu_chk #(
    .NCORES (NCORES),
    .TEMP_W (TEMP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_valid  (pwr_valid),
    .busy       (busy),
    .tile_temp  (tile_temp),
    .temp_valid (temp_valid),
    .overrun    (overrun)
);

// File: tb/tile_temp_emu_tb.sv
`timescale 1ns/1ps
module tile_temp_emu_tb;

    localparam int NC    = 4;
    localparam int PW    = 8;
    localparam int LW    = 2;
    localparam int TW    = 8;
    localparam int IW    = 3 * LW;
    localparam int DEPTH = 1 << IW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pwr_valid = 1'b0;
    logic [NC*PW-1:0] pwr_in = '0;
    logic           tbl_wr = 1'b0;
    logic [IW-1:0]  tbl_addr = '0;
    logic [TW-1:0]  tbl_data = '0;
    logic [TW-1:0]  tile_temp;
    logic           temp_valid;
    logic           overrun;

    int n_checks = 0;
    int n_fails  = 0;
    logic [TW-1:0] model_tbl [DEPTH];
    logic [PW-1:0] cur_p [NC];
    int seed_dummy;

    always #4 clk = ~clk;

    tile_temp_emu #(.NCORES(NC), .PWR_W(PW), .LVL_W(LW), .TEMP_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_in(pwr_in),
        .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .tile_temp(tile_temp), .temp_valid(temp_valid), .overrun(overrun));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int qlvl(input logic [PW-1:0] p);
        int t;
        t = int'(p) >> (PW - LW);
        if (p == 0) return 0;
        if (t == 0) return 1;
        return t;
    endfunction

    function automatic int core_idx(input int c);
        int own, lf, rt;
        own = qlvl(cur_p[c]);
        lf  = (c == 0) ? 0 : qlvl(cur_p[c-1]);
        rt  = (c == NC - 1) ? 0 : qlvl(cur_p[c+1]);
        return (own << (2 * LW)) | (lf << LW) | rt;
    endfunction

    function automatic int exp_temp();
        int m = 0;
        for (int c = 0; c < NC; c++) begin
            if (int'(model_tbl[core_idx(c)]) > m) m = int'(model_tbl[core_idx(c)]);
        end
        return m;
    endfunction

    task automatic write_entry(input int a, input int v);
        @(negedge clk);
        tbl_wr   = 1'b1;
        tbl_addr = IW'(a);
        tbl_data = TW'(v);
        model_tbl[a] = TW'(v);
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic drive_powers();
        for (int c = 0; c < NC; c++) pwr_in[c*PW +: PW] = cur_p[c];
    endtask

    // Strobe one period, wait for the result and check latency, value, pulse width, hold.
    task automatic run_period(input string req, input bit inject_overrun);
        int lat;
        int expv;
        logic [TW-1:0] held;
        expv = exp_temp();
        @(negedge clk);
        drive_powers();
        pwr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pwr_valid = 1'b0;
        lat = 0;
        while (lat < 40) begin
            if (inject_overrun && lat == 1) begin
                for (int c = 0; c < NC; c++) pwr_in[c*PW +: PW] = PW'(255);
                pwr_valid = 1'b1;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
            pwr_valid = 1'b0;
            if (temp_valid) break;
        end
        check({req, " R4 latency"}, lat, NC + 1);
        check({req, " R3 tile maximum"}, tile_temp, expv);
        held = tile_temp;
        @(negedge clk);
        check({req, " R4 pulse width"}, temp_valid, 0);
        @(negedge clk);
        check({req, " R5 hold"}, tile_temp, held);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R5: reset values
        check("R5 reset temp", tile_temp, 0);
        check("R5 reset valid", temp_valid, 0);
        check("R5 reset overrun", overrun, 0);
        rst_n = 1'b1;

        // Identity table for R1/R2 directed checks
        for (int a = 0; a < DEPTH; a++) write_entry(a, a);

        // R1: quantisation boundaries, power only on core 0 -> result = level << 4
        begin
            int pv [6] = '{0, 1, 127, 128, 191, 255};
            int lv [6] = '{0, 1, 1, 2, 2, 3};
            for (int k = 0; k < 6; k++) begin
                for (int c = 0; c < NC; c++) cur_p[c] = '0;
                cur_p[0] = PW'(pv[k]);
                run_period("R1 quantise", 1'b0);
                check("R1 level", tile_temp, lv[k] << (2 * LW));
            end
        end

        // R2: neighbour ordering and edge zeros, only last core active
        for (int c = 0; c < NC; c++) cur_p[c] = '0;
        cur_p[NC-1] = PW'(200);
        run_period("R2 right edge", 1'b0);
        check("R2 last core index", tile_temp, 3 << (2 * LW));
        // core1 at level 1, core2 at level 2: core2 index {2,1,0}=36 is max
        cur_p[NC-1] = '0;
        cur_p[1] = PW'(50);
        cur_p[2] = PW'(150);
        run_period("R2 neighbour order", 1'b0);
        check("R2 ordered index", tile_temp, (2 << 4) | (1 << 2));

        // Random table
        for (int a = 0; a < DEPTH; a++) write_entry(a, 20 + ($urandom % 100));

        // R3: random powers with some inactive cores
        for (int it = 0; it < 30; it++) begin
            for (int c = 0; c < NC; c++) begin
                cur_p[c] = (($urandom % 4) == 0) ? '0 : PW'($urandom);
            end
            run_period("R3 random", 1'b0);
        end

        // R8: hot then cold period, max must be cleared
        write_entry(0, 5);
        write_entry(63, 200);
        for (int c = 0; c < NC; c++) cur_p[c] = PW'(255);
        run_period("R8 hot", 1'b0);
        for (int c = 0; c < NC; c++) cur_p[c] = '0;
        run_period("R8 cold", 1'b0);
        check("R8 cleared max", tile_temp, 5);

        // R7: rewrite an entry and see it next period
        write_entry(0, 77);
        run_period("R7 rewrite", 1'b0);
        check("R7 new entry", tile_temp, 77);

        // R6: strobe during scan ignored, overrun sticky
        check("R6 overrun before", overrun, 0);
        cur_p[0] = PW'(10);
        run_period("R6 ignored strobe", 1'b1);
        check("R6 overrun set", overrun, 1);
        for (int c = 0; c < NC; c++) cur_p[c] = '0;
        run_period("R6 after overrun", 1'b0);
        check("R6 overrun sticky", overrun, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule